// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracking

This block follows a data transfer on a peripheral bus. It holds a 24-bit count of bytes still to move and a 32-bit address that rises by the same amount each time the count falls. Both move only when the bus side confirms that data has actually been transferred, so the tracking address always names the byte that comes next. It never runs ahead of the data the way a prefetching host address can.

The host sets up a transfer with byte-wide register writes. It first writes the start address into a shadow register, then writes the count bytes. Any write to a count byte also copies the shadow start address into the tracking address. Each confirmation pulse moves the count down, and the address up, by one byte, or by two when the wide qualifier is high. Two sticky flags report the state of the transfer: one for a count of zero, and one for a count that wrapped below zero. The host clears either flag by writing 1 to its bit. A per-flag enable routes each flag onto a single interrupt line.

Top module: `xfer_count_track`

## Requirements
- R1: While reset is high, and on leaving it, the count and tracking address are 0, the done flag is 1, the wrap flag is 0, the interrupt enables are 0 and the interrupt is low.
- R2: A write to offset 0, 1 or 2 replaces that byte of the count (offset 0 is the least significant byte) and keeps the other two bytes. In the same cycle it loads the tracking address from the start-address shadow.
- R3: A confirmation pulse with the wide qualifier low lowers the count by 1 and raises the address by 1, visible after the next clock edge. Without a pulse, both hold their values.
- R4: A confirmation pulse with the wide qualifier high lowers the count by 2 and raises the address by 2.
- R5: When the step is larger than the current count, the count wraps modulo 2^24. For example, 0 minus 1 gives 0xFFFFFF and 1 minus 2 gives 0xFFFFFF. The wrap flag is set after the same edge.
- R6: The done flag is set on the edge after any cycle in which the count is zero, and it stays set until it is cleared. Writing 1 to bit 2 at offset 9 clears done, and writing 1 to bit 3 at offset 9 clears wrap. If a set condition and a clear fall in the same cycle, the set wins.
- R7: Writing 1 to bit 4 at offset 8 forces the count to zero. A write at offset 8 with bit 4 at 0 has no effect.
- R8: The interrupt is high exactly when (done AND enable bit 2) OR (wrap AND enable bit 3), where the enable bits are held in the register at offset 10.
- R9: A count-byte write or a count clear in the same cycle as a confirmation pulse takes priority. The pulse is then dropped: the address does not step and no wrap is flagged.
- R10: Writes to the start-address shadow (offsets 4 to 7, with offset 4 as the least significant byte) leave the tracking address unchanged until the next count load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| xfer_ack | input | 1 | Confirms one transfer this cycle |
| xfer_wide | input | 1 | Confirmed transfer carries two bytes |
| remain_cnt | output | 24 | Bytes still to transfer |
| xfer_addr | output | 32 | Address of the next byte |
| done_flag | output | 1 | Sticky count-zero flag |
| wrap_flag | output | 1 | Sticky counter-wrap flag |
| irq | output | 1 | Enabled flags combined |

## Verification
The bench sweeps small start counts against every pattern of narrow and wide steps. This drives the counter through zero, including a wide step from a count of one, which a design that only compares against zero would miss: it would leave wrap clear or settle on the wrong count. Clears are issued while the count is zero and also while it is non-zero, which separates a design that wrongly lets the clear win from one that gives the set condition priority. Confirmation pulses are also issued in the same cycle as loads and clears; a design with the wrong priority would step the address or raise wrap on a freshly loaded count.

// File: rtl/xct_pkg.sv
package xct_pkg;

    localparam int CNT_BYTES_D  = 3;
    localparam int ADDR_BYTES_D = 4;

    // register byte offsets
    localparam logic [3:0] OFS_CNT0   = 4'h0;
    localparam logic [3:0] OFS_START0 = 4'h4;
    localparam logic [3:0] OFS_CTRL   = 4'h8;
    localparam logic [3:0] OFS_CLR    = 4'h9;
    localparam logic [3:0] OFS_IEN    = 4'hA;

    // bit positions inside the control, clear and enable bytes
    localparam int BIT_DONE   = 2;
    localparam int BIT_WRAP   = 3;
    localparam int BIT_CNTCLR = 4;

    typedef struct packed {
        logic wrap;
        logic done;
    } flags_t;

    typedef struct packed {
        logic ack;
        logic wide;
    } xfer_t;

    function automatic logic [1:0] step_of(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/xct_regs.sv
module xct_regs
    import xct_pkg::*;
#(
    parameter int CNT_BYTES  = CNT_BYTES_D,
    parameter int ADDR_BYTES = ADDR_BYTES_D,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [7:0]           wdata,
    output logic [CNT_BYTES-1:0] cnt_wr,
    output logic                 cnt_clr,
    output logic [ADDR_W-1:0]    start_addr,
    output flags_t               clr_flags,
    output flags_t               ien
);

    genvar gi;
    generate
        for (gi = 0; gi < CNT_BYTES; gi++) begin : g_cntsel
            assign cnt_wr[gi] = we && (addr == OFS_CNT0 + 4'(gi));
        end
        for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_start
            always_ff @(posedge clk) begin
                if (rst)
                    start_addr[gi*8 +: 8] <= '0;
                else if (we && (addr == OFS_START0 + 4'(gi)))
                    start_addr[gi*8 +: 8] <= wdata;
            end
        end
    endgenerate

    assign cnt_clr        = we && (addr == OFS_CTRL) && wdata[BIT_CNTCLR];
    assign clr_flags.done = we && (addr == OFS_CLR) && wdata[BIT_DONE];
    assign clr_flags.wrap = we && (addr == OFS_CLR) && wdata[BIT_WRAP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= '0;
        end else if (we && (addr == OFS_IEN)) begin
            ien.done <= wdata[BIT_DONE];
            ien.wrap <= wdata[BIT_WRAP];
        end
    end

endmodule

// File: rtl/xct_datapath.sv
module xct_datapath
    import xct_pkg::*;
#(
    parameter int CNT_BYTES  = CNT_BYTES_D,
    parameter int ADDR_BYTES = ADDR_BYTES_D,
    localparam int CNT_W     = CNT_BYTES * 8,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_BYTES-1:0] cnt_wr,
    input  logic [7:0]           wdata,
    input  logic                 cnt_clr,
    input  logic [ADDR_W-1:0]    start_addr,
    input  xfer_t                xfer,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic                 wrap_evt
);

    logic [CNT_W-1:0]  cnt_ld;
    logic [CNT_W-1:0]  cnt_step;
    logic [ADDR_W-1:0] addr_step;
    logic              load;
    logic              advance;

    always_comb begin
        cnt_step  = CNT_W'(step_of(xfer.wide));
        addr_step = ADDR_W'(step_of(xfer.wide));
        load      = |cnt_wr;
        cnt_ld    = cnt_q;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (cnt_wr[b]) cnt_ld[b*8 +: 8] = wdata;
        end
        advance  = xfer.ack && !load && !cnt_clr;
        wrap_evt = advance && (cnt_step > cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (cnt_clr) begin
            cnt_q  <= '0;
        end else if (load) begin
            cnt_q  <= cnt_ld;
            addr_q <= start_addr;
        end else if (advance) begin
            cnt_q  <= cnt_q - cnt_step;
            addr_q <= addr_q + addr_step;
        end
    end

endmodule

// File: rtl/xct_status.sv
module xct_status
    import xct_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cnt_zero,
    input  logic   wrap_evt,
    input  flags_t clr_flags,
    input  flags_t ien,
    output flags_t flags,
    output logic   irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags.done <= 1'b1;
            flags.wrap <= 1'b0;
        end else begin
            flags.done <= (flags.done && !clr_flags.done) || cnt_zero;
            flags.wrap <= (flags.wrap && !clr_flags.wrap) || wrap_evt;
        end
    end

    assign irq = (flags.done && ien.done) || (flags.wrap && ien.wrap);

endmodule

// File: rtl/xfer_count_track.sv
module xfer_count_track
    import xct_pkg::*;
#(
    parameter int CNT_BYTES  = CNT_BYTES_D,
    parameter int ADDR_BYTES = ADDR_BYTES_D,
    localparam int CNT_W     = CNT_BYTES * 8,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              xfer_ack,
    input  logic              xfer_wide,
    output logic [CNT_W-1:0]  remain_cnt,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done_flag,
    output logic              wrap_flag,
    output logic              irq
);

    logic [CNT_BYTES-1:0] cnt_wr;
    logic                 cnt_clr;
    logic [ADDR_W-1:0]    start_addr;
    flags_t               clr_flags;
    flags_t               ien;
    flags_t               flags;
    xfer_t                xfer;
    logic                 wrap_evt;

    assign xfer.ack  = xfer_ack;
    assign xfer.wide = xfer_wide;

    xct_regs #(.CNT_BYTES(CNT_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cnt_wr(cnt_wr), .cnt_clr(cnt_clr), .start_addr(start_addr),
        .clr_flags(clr_flags), .ien(ien)
    );

    xct_datapath #(.CNT_BYTES(CNT_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_dp (
        .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .wdata(reg_wdata),
        .cnt_clr(cnt_clr), .start_addr(start_addr), .xfer(xfer),
        .cnt_q(remain_cnt), .addr_q(xfer_addr), .wrap_evt(wrap_evt)
    );

    xct_status u_stat (
        .clk(clk), .rst(rst), .cnt_zero(remain_cnt == '0), .wrap_evt(wrap_evt),
        .clr_flags(clr_flags), .ien(ien), .flags(flags), .irq(irq)
    );

    assign done_flag = flags.done;
    assign wrap_flag = flags.wrap;

endmodule

// File: rtl/xct_chk.sv
module xct_chk #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              xfer_ack,
    input logic              xfer_wide,
    input logic [CNT_W-1:0]  remain_cnt,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              done_flag,
    input logic              wrap_flag,
    input logic              irq
);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !reg_we) |=>
        remain_cnt == $past(remain_cnt - CNT_W'(xfer_wide ? 2 : 1)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !reg_we) |=>
        xfer_addr == $past(xfer_addr + ADDR_W'(xfer_wide ? 2 : 1)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer_ack && !reg_we) |=> ($stable(remain_cnt) && $stable(xfer_addr)));

    // R5
    wrap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !reg_we && (remain_cnt < CNT_W'(xfer_wide ? 2 : 1))) |=> wrap_flag);

    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (remain_cnt == '0) |=> done_flag);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 4'h8 && reg_wdata[4]) |=> (remain_cnt == '0));

    // R8
    always @(negedge clk) begin
        if (!rst) irq_src_chk: assert (!irq || done_flag || wrap_flag);
    end

endmodule

bind xfer_count_track xct_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xfer_ack(xfer_ack), .xfer_wide(xfer_wide),
    .remain_cnt(remain_cnt), .xfer_addr(xfer_addr), .done_flag(done_flag),
    .wrap_flag(wrap_flag), .irq(irq)
);

// File: tb/sim_xfer_count_track.sv
`timescale 1ns/1ps
module sim_xfer_count_track;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        xfer_ack;
    logic        xfer_wide;
    logic [23:0] remain_cnt;
    logic [31:0] xfer_addr;
    logic        done_flag, wrap_flag, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] m_cnt;
    logic [31:0] m_addr, m_start;
    logic        m_done, m_wrap;
    logic [1:0]  m_en;   // [0] done enable (bit 2), [1] wrap enable (bit 3)

    always #2 clk = ~clk;

    xfer_count_track u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .xfer_ack(xfer_ack), .xfer_wide(xfer_wide),
        .remain_cnt(remain_cnt), .xfer_addr(xfer_addr), .done_flag(done_flag),
        .wrap_flag(wrap_flag), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "count", 32'(remain_cnt), 32'(m_cnt));
        chk(tag, "addr", xfer_addr, m_addr);
        chk(tag, "done", 32'(done_flag), 32'(m_done));
        chk(tag, "wrap", 32'(wrap_flag), 32'(m_wrap));
        chk("R8", "irq", 32'(irq), 32'((m_done & m_en[0]) | (m_wrap & m_en[1])));
    endtask

    // called at a negedge: drive, clock once, sample at the following negedge
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic ack, input logic wide, input string tag);
        logic ld, clrc, nd, nw;
        logic [23:0] stp;
        reg_we = we; reg_addr = a; reg_wdata = d; xfer_ack = ack; xfer_wide = wide;
        ld   = we && (a < 4'd3);
        clrc = we && (a == 4'd8) && d[4];
        stp  = wide ? 24'd2 : 24'd1;
        nd = (m_done && !(we && a == 4'd9 && d[2])) || (m_cnt == 24'd0);
        nw = (m_wrap && !(we && a == 4'd9 && d[3])) || (ack && !ld && !clrc && (stp > m_cnt));
        if (clrc) m_cnt = 24'd0;
        else if (ld) begin
            m_cnt[a*8 +: 8] = d;
            m_addr = m_start;
        end else if (ack) begin
            m_cnt  = m_cnt - stp;
            m_addr = m_addr + 32'(stp);
        end
        if (we && a >= 4'd4 && a < 4'd8) m_start[(a-4)*8 +: 8] = d;
        if (we && a == 4'd10) m_en = d[3:2];
        m_done = nd;
        m_wrap = nw;
        @(posedge clk);
        @(negedge clk);
        reg_we = 0; xfer_ack = 0; xfer_wide = 0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 4'h0, 8'h00, 0, 0, tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0; xfer_ack = 0; xfer_wide = 0;
        m_cnt = 0; m_addr = 0; m_start = 0; m_done = 1; m_wrap = 0; m_en = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 0;
        @(negedge clk);
        check_all("R1");

        // R10: shadow start address writes do not move the tracking address
        step(1, 4'h4, 8'h10, 0, 0, "R10");
        step(1, 4'h5, 8'h20, 0, 0, "R10");
        step(1, 4'h6, 8'h30, 0, 0, "R10");
        step(1, 4'h7, 8'h40, 0, 0, "R10");
        // R2: byte loads
        step(1, 4'h0, 8'h12, 0, 0, "R2");
        step(1, 4'h1, 8'h34, 0, 0, "R2");
        step(1, 4'h2, 8'h56, 0, 0, "R2");
        step(1, 4'h1, 8'hAB, 0, 0, "R2");
        // R6: clear done while non-zero
        step(1, 4'h9, 8'h04, 0, 0, "R6");
        // R3 / R4
        step(0, 4'h0, 8'h00, 1, 0, "R3");
        idle("R3");
        step(0, 4'h0, 8'h00, 1, 1, "R4");
        step(0, 4'h0, 8'h00, 1, 0, "R3");
        // R7: control write with bit 4 clear has no effect, then with bit 4 set
        step(1, 4'h8, 8'hEF, 0, 0, "R7");
        step(1, 4'h8, 8'h10, 0, 0, "R7");
        idle("R6");
        // R6: clear done while count is zero: set wins
        step(1, 4'h9, 8'h04, 0, 0, "R6");
        // R9: load and clear beat a simultaneous pulse
        step(1, 4'h0, 8'h05, 1, 1, "R9");
        step(1, 4'h8, 8'h10, 1, 0, "R9");
        idle("R9");
        // R8: enable both interrupt sources
        step(1, 4'hA, 8'h0C, 0, 0, "R8");

        // sweep start counts against all narrow/wide patterns
        for (int c0 = 0; c0 < 5; c0++) begin
            for (int pat = 0; pat < 16; pat++) begin
                step(1, 4'h8, 8'h10, 0, 0, "R7");
                step(1, 4'h5, 8'(pat), 0, 0, "R10");
                step(1, 4'h0, 8'(c0), 0, 0, "R2");
                step(1, 4'h9, 8'h0C, 0, 0, "R6");
                for (int i = 0; i < 4; i++) begin
                    logic [23:0] s;
                    s = pat[i] ? 24'd2 : 24'd1;
                    step(0, 4'h0, 8'h00, 1, pat[i], (s > m_cnt) ? "R5" : (pat[i] ? "R4" : "R3"));
                end
                idle("R6");
                if (pat == 7) step(1, 4'hA, 8'(c0[0] ? 8'h04 : 8'h08), 0, 0, "R8");
            end
        end

        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0)
                step(1, 4'(lfsr[7:4] % 11), lfsr[15:8], lfsr[1], lfsr[2], "R9");
            else
                step(0, 4'h0, 8'h00, lfsr[1] | lfsr[5], lfsr[2], "R3");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule